// File: doc/BRIEF.md
# Broadcast Ring Receive Hub

This block is the receive end of one cluster's hub on a shared broadcast ring. Every sender on the ring owns a private channel, so any or all of the 64 senders can deliver a flit in the same cycle. Each delivery is a 32-bit flit plus a metadata word. The metadata carries a route kind, a message type, a tag and a unicast destination. The hub writes each delivery into a small FIFO owned by that sender. It then decides whether the local cluster is a destination and passes accepted messages to the cluster's cores over two parallel downstream ports.

Unicast messages name one cluster and one core. Multicast messages arrive as a header flit listing up to three destinations, followed by a body flit. Broadcast messages are always taken. Rejected flits and multicast headers leave their FIFO without using an output slot. Heads that are accepted compete in round-robin order for the two output ports. A per-sender hold signal tells each sender to stop before its FIFO overflows. The hold signal reaches the sender one cycle late, so it is raised while one slot is still free.

Top module: `ring_rx_hub`

## Requirements
- R1: During and directly after reset, both output valids and every bit of `senderHold` are low.
- R2: Flits from all 64 senders can be captured in the same cycle and none is lost while a sender respects its hold. Flits from one sender leave in the order they arrived.
- R3: Metadata layout is kind[18:17], type[16:14], tag[13:10], destination cluster[9:4], destination core[3:0]. A forwarded flit leaves with its data, type and tag unchanged and with the index of its sender.
- R4: A kind 0 (unicast) flit is forwarded only when its destination cluster equals `clusterId`, with a core mask that has only bit `core` set. Otherwise it is dropped and produces no output.
- R5: A kind 1 (broadcast) flit is always forwarded, with a core mask of all ones.
- R6: A kind 2 flit is a multicast header and is never forwarded. Its data holds an entry count in [31:30] and entry i at [10i+9:10i], where each entry is {cluster[5:0], core[3:0]}. The next kind 3 flit from the same sender is forwarded if at least one of the first count entries names `clusterId`. Its core mask is the OR of the matching cores. Otherwise that flit is dropped. A kind 3 flit with no preceding header is dropped.
- R7: At most two flits leave per cycle. Port 1 is valid only when port 0 is valid, and the two ports never carry the same sender in one cycle.
- R8: Senders are granted in round-robin order. A sender with a backlog is not served a second time while another waiting sender has not yet been served.
- R9: `senderHold[s]` is high while sender s's FIFO holds FIFO_DEPTH-1 or more flits. It returns low once the FIFO drains.
- R10: A flit captured at a clock edge into an empty FIFO, with no competing sender, appears on port 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clusterId | input | 6 | Identity of the local cluster |
| ringValid | input | 64 | One valid per sender channel |
| ringData | input | 2048 | 32-bit flit per sender, sender s at [32s+31:32s] |
| ringMeta | input | 1216 | 19-bit metadata per sender, sender s at [19s+18:19s] |
| senderHold | output | 64 | Per-sender backpressure |
| out0Valid | output | 1 | Port 0 carries a flit |
| out0Data | output | 32 | Port 0 flit |
| out0Type | output | 3 | Port 0 message type |
| out0Tag | output | 4 | Port 0 tag |
| out0Src | output | 6 | Port 0 sender index |
| out0CoreMask | output | 16 | Port 0 destination cores |
| out1Valid | output | 1 | Port 1 carries a flit |
| out1Data | output | 32 | Port 1 flit |
| out1Type | output | 3 | Port 1 message type |
| out1Tag | output | 4 | Port 1 tag |
| out1Src | output | 6 | Port 1 sender index |
| out1CoreMask | output | 16 | Port 1 destination cores |

## Verification
The bench uses the package defaults: 64 senders, 4-deep FIFOs and 32-bit flits, with the cluster identity tied to 9. At this sender count, one cycle of traffic from every sender keeps both ports busy for 32 cycles, which exercises the dual grant at full width. The 4-deep FIFOs mean that four back-to-back waves from all senders are enough to reach the hold threshold on nearly every channel without loss. The multicast cases place the matching entry in each of the three slots and include an entry beyond the count, so the count field itself is tested.

// File: rtl/hubrx_pkg.sv
`timescale 1ns/1ps
package hubrx_pkg;
  parameter int NUM_SENDERS = 64;
  parameter int FLIT_W      = 32;
  parameter int TYPE_W      = 3;
  parameter int TAG_W       = 4;
  parameter int CLUSTER_W   = 6;
  parameter int CORE_W      = 4;
  parameter int FIFO_DEPTH  = 4;

  localparam int KIND_W    = 2;
  localparam int NUM_CORES = 1 << CORE_W;
  localparam int DEST_W    = CLUSTER_W + CORE_W;
  localparam int META_W    = KIND_W + TYPE_W + TAG_W + DEST_W;
  localparam int SRC_W     = $clog2(NUM_SENDERS);
  localparam int MC_CNT_W  = 2;
  localparam int MC_SLOTS  = (FLIT_W - MC_CNT_W) / DEST_W;

  typedef enum logic [KIND_W-1:0] {
    ROUTE_UNI    = 2'd0,
    ROUTE_ALL    = 2'd1,
    ROUTE_MCHDR  = 2'd2,
    ROUTE_MCBODY = 2'd3
  } route_e;

  typedef struct packed {
    route_e                route;
    logic [TYPE_W-1:0]     msgType;
    logic [TAG_W-1:0]      tag;
    logic [CLUSTER_W-1:0]  dstCluster;
    logic [CORE_W-1:0]     dstCore;
  } meta_t;

  // What the control needs to see of each FIFO head
  typedef struct packed {
    route_e                route;
    logic [CLUSTER_W-1:0]  dstCluster;
    logic [CORE_W-1:0]     dstCore;
    logic [FLIT_W-1:0]     flit;
  } head_view_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_SENDERS-1:0] popMask;
    logic [1:0]             grantValid;
    logic [SRC_W-1:0]       grant0;
    logic [SRC_W-1:0]       grant1;
    logic [NUM_CORES-1:0]   mask0;
    logic [NUM_CORES-1:0]   mask1;
  } strobe_t;
endpackage

// File: rtl/hubrx_fifo.sv
`timescale 1ns/1ps
module hubrx_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 51
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pushValid,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             hold
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] fill;
  logic doPush, doPop;

  assign doPush = pushValid && (fill != CNT_W'(DEPTH));
  assign doPop  = pop && (fill != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr <= '0;
      wrPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      fill <= fill + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= pushData;
  end

  assign headData = store[rdPtr];
  assign empty    = (fill == '0);
  assign hold     = (fill >= CNT_W'(DEPTH - 1));
endmodule

// File: rtl/hubrx_ctrl.sv
`timescale 1ns/1ps
module hubrx_ctrl
  import hubrx_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst,
  input  logic [CLUSTER_W-1:0]             clusterId,
  input  head_view_t [NUM_SENDERS-1:0]     heads,
  input  logic [NUM_SENDERS-1:0]           fifoEmpty,
  output strobe_t                          strobes
);
  logic [NUM_SENDERS-1:0]                 fwd;
  logic [NUM_SENDERS-1:0]                 want;
  logic [NUM_SENDERS-1:0][NUM_CORES-1:0]  fwdMask;
  logic [NUM_SENDERS-1:0][NUM_CORES-1:0]  hdrMask;
  logic [NUM_SENDERS-1:0]                 mcLive;
  logic [NUM_SENDERS-1:0][NUM_CORES-1:0]  mcMask;
  logic [SRC_W-1:0]                       rrPtr;
  logic                                   g0v, g1v;
  logic [SRC_W-1:0]                       g0, g1;
  logic [NUM_SENDERS-1:0]                 popMask;

  // Per-sender decode of the head flit
  always_comb begin
    for (int s = 0; s < NUM_SENDERS; s++) begin
      hdrMask[s] = '0;
      for (int i = 0; i < MC_SLOTS; i++) begin
        if ((i < int'(heads[s].flit[FLIT_W-1 -: MC_CNT_W])) &&
            (heads[s].flit[i*DEST_W + CORE_W +: CLUSTER_W] == clusterId))
          hdrMask[s][heads[s].flit[i*DEST_W +: CORE_W]] = 1'b1;
      end
      fwd[s]     = 1'b0;
      fwdMask[s] = '0;
      case (heads[s].route)
        ROUTE_UNI: begin
          fwd[s]     = (heads[s].dstCluster == clusterId);
          fwdMask[s] = NUM_CORES'(1) << heads[s].dstCore;
        end
        ROUTE_ALL: begin
          fwd[s]     = 1'b1;
          fwdMask[s] = '1;
        end
        ROUTE_MCBODY: begin
          fwd[s]     = mcLive[s];
          fwdMask[s] = mcMask[s];
        end
        default: begin
          fwd[s]     = 1'b0;
          fwdMask[s] = '0;
        end
      endcase
    end
    want = fwd & ~fifoEmpty;
  end

  // Two grants in rotating order starting at rrPtr
  always_comb begin
    int idx;
    idx = 0;
    g0v = 1'b0;
    g1v = 1'b0;
    g0  = '0;
    g1  = '0;
    for (int k = 0; k < NUM_SENDERS; k++) begin
      idx = (int'(rrPtr) + k) % NUM_SENDERS;
      if (want[idx]) begin
        if (!g0v) begin
          g0v = 1'b1;
          g0  = SRC_W'(idx);
        end else if (!g1v) begin
          g1v = 1'b1;
          g1  = SRC_W'(idx);
        end
      end
    end
  end

  always_comb begin
    for (int s = 0; s < NUM_SENDERS; s++) begin
      popMask[s] = (!fifoEmpty[s] && !fwd[s]) ||
                   (g0v && (g0 == SRC_W'(s))) ||
                   (g1v && (g1 == SRC_W'(s)));
    end
    strobes.popMask    = popMask;
    strobes.grantValid = {g1v, g0v};
    strobes.grant0     = g0;
    strobes.grant1     = g1;
    strobes.mask0      = fwdMask[g0];
    strobes.mask1      = fwdMask[g1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mcLive <= '0;
      mcMask <= '0;
      rrPtr  <= '0;
    end else begin
      for (int s = 0; s < NUM_SENDERS; s++) begin
        if (popMask[s]) begin
          if (heads[s].route == ROUTE_MCHDR) begin
            mcLive[s] <= |hdrMask[s];
            mcMask[s] <= hdrMask[s];
          end else if (heads[s].route == ROUTE_MCBODY) begin
            mcLive[s] <= 1'b0;
          end
        end
      end
      if (g1v)      rrPtr <= SRC_W'((int'(g1) + 1) % NUM_SENDERS);
      else if (g0v) rrPtr <= SRC_W'((int'(g0) + 1) % NUM_SENDERS);
    end
  end
endmodule

// File: rtl/hubrx_datapath.sv
`timescale 1ns/1ps
module hubrx_datapath
  import hubrx_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_SENDERS-1:0]          ringValid,
  input  logic [NUM_SENDERS*FLIT_W-1:0]   ringData,
  input  logic [NUM_SENDERS*META_W-1:0]   ringMeta,
  input  strobe_t                         strobes,
  output head_view_t [NUM_SENDERS-1:0]    heads,
  output logic [NUM_SENDERS-1:0]          fifoEmpty,
  output logic [NUM_SENDERS-1:0]          senderHold,
  output logic                            out0Valid,
  output logic [FLIT_W-1:0]               out0Data,
  output logic [TYPE_W-1:0]               out0Type,
  output logic [TAG_W-1:0]                out0Tag,
  output logic [SRC_W-1:0]                out0Src,
  output logic [NUM_CORES-1:0]            out0CoreMask,
  output logic                            out1Valid,
  output logic [FLIT_W-1:0]               out1Data,
  output logic [TYPE_W-1:0]               out1Type,
  output logic [TAG_W-1:0]                out1Tag,
  output logic [SRC_W-1:0]                out1Src,
  output logic [NUM_CORES-1:0]            out1CoreMask
);
  localparam int ENTRY_W = FLIT_W + META_W;

  logic [NUM_SENDERS-1:0][FLIT_W-1:0] headFlit;
  meta_t [NUM_SENDERS-1:0]            headMeta;

  for (genvar s = 0; s < NUM_SENDERS; s++) begin : g_sender
    logic [ENTRY_W-1:0] entryOut;
    hubrx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(ENTRY_W)) u_fifo (
      .clk      (clk),
      .rst      (rst),
      .pushValid(ringValid[s]),
      .pushData ({ringData[s*FLIT_W +: FLIT_W], ringMeta[s*META_W +: META_W]}),
      .pop      (strobes.popMask[s]),
      .headData (entryOut),
      .empty    (fifoEmpty[s]),
      .hold     (senderHold[s])
    );
    assign headFlit[s] = entryOut[ENTRY_W-1 -: FLIT_W];
    assign headMeta[s] = meta_t'(entryOut[META_W-1:0]);
    assign heads[s]    = {headMeta[s].route, headMeta[s].dstCluster,
                          headMeta[s].dstCore, headFlit[s]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out0Valid    <= 1'b0;
      out1Valid    <= 1'b0;
      out0Data     <= '0;
      out0Type     <= '0;
      out0Tag      <= '0;
      out0Src      <= '0;
      out0CoreMask <= '0;
      out1Data     <= '0;
      out1Type     <= '0;
      out1Tag      <= '0;
      out1Src      <= '0;
      out1CoreMask <= '0;
    end else begin
      out0Valid    <= strobes.grantValid[0];
      out1Valid    <= strobes.grantValid[1];
      out0Data     <= headFlit[strobes.grant0];
      out0Type     <= headMeta[strobes.grant0].msgType;
      out0Tag      <= headMeta[strobes.grant0].tag;
      out0Src      <= strobes.grant0;
      out0CoreMask <= strobes.mask0;
      out1Data     <= headFlit[strobes.grant1];
      out1Type     <= headMeta[strobes.grant1].msgType;
      out1Tag      <= headMeta[strobes.grant1].tag;
      out1Src      <= strobes.grant1;
      out1CoreMask <= strobes.mask1;
    end
  end
endmodule

// File: rtl/ring_rx_hub.sv
`timescale 1ns/1ps
module ring_rx_hub
  import hubrx_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst,
  input  logic [CLUSTER_W-1:0]            clusterId,
  input  logic [NUM_SENDERS-1:0]          ringValid,
  input  logic [NUM_SENDERS*FLIT_W-1:0]   ringData,
  input  logic [NUM_SENDERS*META_W-1:0]   ringMeta,
  output logic [NUM_SENDERS-1:0]          senderHold,
  output logic                            out0Valid,
  output logic [FLIT_W-1:0]               out0Data,
  output logic [TYPE_W-1:0]               out0Type,
  output logic [TAG_W-1:0]                out0Tag,
  output logic [SRC_W-1:0]                out0Src,
  output logic [NUM_CORES-1:0]            out0CoreMask,
  output logic                            out1Valid,
  output logic [FLIT_W-1:0]               out1Data,
  output logic [TYPE_W-1:0]               out1Type,
  output logic [TAG_W-1:0]                out1Tag,
  output logic [SRC_W-1:0]                out1Src,
  output logic [NUM_CORES-1:0]            out1CoreMask
);
  strobe_t                         strobes;
  head_view_t [NUM_SENDERS-1:0]    heads;
  logic [NUM_SENDERS-1:0]          fifoEmpty;

  hubrx_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .clusterId(clusterId),
    .heads    (heads),
    .fifoEmpty(fifoEmpty),
    .strobes  (strobes)
  );

  hubrx_datapath u_dp (
    .clk         (clk),
    .rst         (rst),
    .ringValid   (ringValid),
    .ringData    (ringData),
    .ringMeta    (ringMeta),
    .strobes     (strobes),
    .heads       (heads),
    .fifoEmpty   (fifoEmpty),
    .senderHold  (senderHold),
    .out0Valid   (out0Valid),
    .out0Data    (out0Data),
    .out0Type    (out0Type),
    .out0Tag     (out0Tag),
    .out0Src     (out0Src),
    .out0CoreMask(out0CoreMask),
    .out1Valid   (out1Valid),
    .out1Data    (out1Data),
    .out1Type    (out1Type),
    .out1Tag     (out1Tag),
    .out1Src     (out1Src),
    .out1CoreMask(out1CoreMask)
  );
endmodule

// File: rtl/ring_rx_hub_chk.sv
`timescale 1ns/1ps
module ring_rx_hub_chk
  import hubrx_pkg::*;
(
  input logic                    clk,
  input logic                    rst,
  input logic [NUM_SENDERS-1:0]  ringValid,
  input logic [NUM_SENDERS-1:0]  senderHold,
  input logic                    out0Valid,
  input logic                    out1Valid,
  input logic [SRC_W-1:0]        out0Src,
  input logic [SRC_W-1:0]        out1Src,
  input logic [NUM_CORES-1:0]    out0CoreMask,
  input logic [NUM_CORES-1:0]    out1CoreMask
);
  p_distinct_src_r7: assert property (@(posedge clk) disable iff (rst)
    (out0Valid && out1Valid) |-> (out0Src != out1Src))
    else $error("two ports carry one sender");

  p_port_order_r7: assert property (@(posedge clk) disable iff (rst)
    out1Valid |-> out0Valid)
    else $error("port 1 valid without port 0");

  p_mask0_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    out0Valid |-> (out0CoreMask != '0))
    else $error("port 0 forwards to no core");

  p_mask1_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
    out1Valid |-> (out1CoreMask != '0))
    else $error("port 1 forwards to no core");

  p_hold_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(|senderHold) |-> $past(|ringValid))
    else $error("hold rose without a capture");
endmodule

bind ring_rx_hub ring_rx_hub_chk u_chk (.*);

// File: tb/ring_rx_hub_bench.sv
`timescale 1ns/1ps
module ring_rx_hub_bench;
  import hubrx_pkg::*;

  localparam int ITEM_W = FLIT_W + TYPE_W + TAG_W + NUM_CORES;
  localparam logic [CLUSTER_W-1:0] MY_CLUSTER = 6'd9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CLUSTER_W-1:0]          clusterId = MY_CLUSTER;
  logic [NUM_SENDERS-1:0]        ringValid = '0;
  logic [NUM_SENDERS*FLIT_W-1:0] ringData = '0;
  logic [NUM_SENDERS*META_W-1:0] ringMeta = '0;
  logic [NUM_SENDERS-1:0]        senderHold;
  logic                          out0Valid, out1Valid;
  logic [FLIT_W-1:0]             out0Data, out1Data;
  logic [TYPE_W-1:0]             out0Type, out1Type;
  logic [TAG_W-1:0]              out0Tag, out1Tag;
  logic [SRC_W-1:0]              out0Src, out1Src;
  logic [NUM_CORES-1:0]          out0CoreMask, out1CoreMask;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int bothCycles = 0;
  bit recOn = 0;
  int orderLog [$];
  int seenFrom [NUM_SENDERS];
  logic [ITEM_W-1:0] expQ [NUM_SENDERS][$];

  always #4 clk = ~clk;

  ring_rx_hub u_ring_rx_hub (.*);

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic stage(int src, route_e rt, logic [TYPE_W-1:0] ty, logic [TAG_W-1:0] tg,
                       logic [CLUSTER_W-1:0] cl, logic [CORE_W-1:0] co, logic [FLIT_W-1:0] d);
    ringValid[src] = 1'b1;
    ringData[src*FLIT_W +: FLIT_W] = d;
    ringMeta[src*META_W +: META_W] = {rt, ty, tg, cl, co};
  endtask

  task automatic expectItem(int src, logic [FLIT_W-1:0] d, logic [TYPE_W-1:0] ty,
                            logic [TAG_W-1:0] tg, logic [NUM_CORES-1:0] m);
    expQ[src].push_back({d, ty, tg, m});
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    ringValid = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  function automatic logic [FLIT_W-1:0] mcHdr(int cnt, logic [DEST_W-1:0] e0,
                                              logic [DEST_W-1:0] e1, logic [DEST_W-1:0] e2);
    return {2'(cnt), e2, e1, e0};
  endfunction

  task automatic checkQueuesEmpty(string req);
    for (int s = 0; s < NUM_SENDERS; s++) begin
      if (expQ[s].size() != 0)
        check(0, req, $sformatf("sender %0d items never delivered", s), expQ[s].size(), 0);
    end
    check(1, req, "queues drained", 0, 0);
  endtask

  task automatic checkOut(int src, logic [ITEM_W-1:0] got, string port);
    logic [ITEM_W-1:0] want;
    total++;
    seenFrom[src]++;
    if (recOn) orderLog.push_back(src);
    if (expQ[src].size() == 0) begin
      bad++;
      $display("FAIL R2 %s unexpected item from sender %0d: actual=%h expected=none", port, src, got);
    end else begin
      want = expQ[src].pop_front();
      if (got !== want) begin
        bad++;
        $display("FAIL R3 %s sender %0d: actual=%h expected=%h", port, src, got, want);
      end
    end
  endtask

  // Monitor: compares every output against the per-sender expectation
  always @(negedge clk) begin
    if (!rst) begin
      if (out0Valid) checkOut(int'(out0Src), {out0Data, out0Type, out0Tag, out0CoreMask}, "port0");
      if (out1Valid) checkOut(int'(out1Src), {out1Data, out1Type, out1Tag, out1CoreMask}, "port1");
      if (out1Valid && !out0Valid) check(0, "R7", "port1 without port0", 1, 0);
      if (out0Valid && out1Valid) begin
        bothCycles++;
        if (out0Src == out1Src) check(0, "R7", "same sender on both ports", out1Src, -1);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NUM_SENDERS; s++) seenFrom[s] = 0;
    @(negedge clk);
    check(out0Valid == 1'b0 && out1Valid == 1'b0, "R1", "valids in reset", {out0Valid, out1Valid}, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out0Valid == 1'b0 && out1Valid == 1'b0, "R1", "valids after reset", {out0Valid, out1Valid}, 0);
    check(senderHold == '0, "R1", "hold after reset", $countones(senderHold), 0);

    // R10 latency and R4 unicast hit
    stage(5, ROUTE_UNI, 3'd2, 4'd7, MY_CLUSTER, 4'd3, 32'hA5A5_0001);
    expectItem(5, 32'hA5A5_0001, 3'd2, 4'd7, 16'h0008);
    tick();
    check(out0Valid == 1'b0, "R10", "not yet after capture edge", out0Valid, 0);
    @(posedge clk);
    @(negedge clk);
    check(out0Valid == 1'b1 && out0Src == 6'd5, "R10", "visible after next edge", out0Src, 5);
    idle(3);

    // R4 unicast miss alongside a hit
    stage(6, ROUTE_UNI, 3'd1, 4'd1, 6'd10, 4'd3, 32'h0000_0606);
    stage(7, ROUTE_UNI, 3'd4, 4'd2, MY_CLUSTER, 4'd15, 32'h0000_0707);
    expectItem(7, 32'h0000_0707, 3'd4, 4'd2, 16'h8000);
    idle(5);
    check(seenFrom[6] == 0, "R4", "wrong-cluster unicast dropped", seenFrom[6], 0);
    check(seenFrom[7] == 1, "R4", "matching unicast delivered", seenFrom[7], 1);

    // R5 broadcast to all cores, from a foreign cluster field
    stage(8, ROUTE_ALL, 3'd5, 4'd9, 6'd33, 4'd0, 32'hBEEF_0008);
    expectItem(8, 32'hBEEF_0008, 3'd5, 4'd9, 16'hFFFF);
    idle(5);
    check(seenFrom[8] == 1, "R5", "broadcast delivered", seenFrom[8], 1);

    // R6 multicast headers then bodies
    stage(20, ROUTE_MCHDR, 3'd0, 4'd0, 6'd0, 4'd0, mcHdr(2, {6'd3, 4'd1}, {MY_CLUSTER, 4'd12}, {MY_CLUSTER, 4'd5}));
    stage(21, ROUTE_MCHDR, 3'd0, 4'd0, 6'd0, 4'd0, mcHdr(3, {MY_CLUSTER, 4'd2}, {MY_CLUSTER, 4'd7}, {6'd1, 4'd1}));
    stage(22, ROUTE_MCHDR, 3'd0, 4'd0, 6'd0, 4'd0, mcHdr(3, {6'd4, 4'd4}, {6'd5, 4'd5}, {6'd6, 4'd6}));
    stage(23, ROUTE_MCBODY, 3'd3, 4'd3, 6'd0, 4'd0, 32'h0000_2323);
    stage(24, ROUTE_MCHDR, 3'd0, 4'd0, 6'd0, 4'd0, mcHdr(3, {6'd2, 4'd2}, {6'd3, 4'd3}, {MY_CLUSTER, 4'd15}));
    tick();
    stage(20, ROUTE_MCBODY, 3'd6, 4'd10, 6'd0, 4'd0, 32'hC0DE_0020);
    stage(21, ROUTE_MCBODY, 3'd6, 4'd11, 6'd0, 4'd0, 32'hC0DE_0021);
    stage(22, ROUTE_MCBODY, 3'd6, 4'd12, 6'd0, 4'd0, 32'hC0DE_0022);
    stage(24, ROUTE_MCBODY, 3'd6, 4'd13, 6'd0, 4'd0, 32'hC0DE_0024);
    expectItem(20, 32'hC0DE_0020, 3'd6, 4'd10, 16'h1000);
    expectItem(21, 32'hC0DE_0021, 3'd6, 4'd11, 16'h0084);
    expectItem(24, 32'hC0DE_0024, 3'd6, 4'd13, 16'h8000);
    idle(6);
    check(seenFrom[20] == 1 && seenFrom[21] == 1 && seenFrom[24] == 1, "R6", "matching multicast bodies",
          seenFrom[20] + seenFrom[21] + seenFrom[24], 3);
    check(seenFrom[22] == 0, "R6", "unmatched multicast dropped", seenFrom[22], 0);
    check(seenFrom[23] == 0, "R6", "body without header dropped", seenFrom[23], 0);

    // R7 and R2: every sender in one cycle
    bothCycles = 0;
    for (int s = 0; s < NUM_SENDERS; s++) begin
      stage(s, ROUTE_ALL, 3'd1, 4'(s), 6'd0, 4'd0, 32'h5000_0000 | 32'(s));
      expectItem(s, 32'h5000_0000 | 32'(s), 3'd1, 4'(s), 16'hFFFF);
    end
    idle(40);
    check(bothCycles == NUM_SENDERS / 2, "R7", "cycles with two grants", bothCycles, NUM_SENDERS / 2);
    checkQueuesEmpty("R2");

    // R8 round robin among four backlogged senders
    orderLog.delete();
    recOn = 1;
    for (int w = 0; w < 2; w++) begin
      for (int s = 40; s < 44; s++) begin
        stage(s, ROUTE_UNI, 3'd2, 4'(w), MY_CLUSTER, 4'(s % 16), 32'h8800_0000 | 32'(s * 4 + w));
        expectItem(s, 32'h8800_0000 | 32'(s * 4 + w), 3'd2, 4'(w), NUM_CORES'(1) << (s % 16));
      end
      tick();
    end
    idle(8);
    recOn = 0;
    check(orderLog.size() == 8, "R8", "items delivered", orderLog.size(), 8);
    if (orderLog.size() >= 4) begin
      bit [3:0] hit;
      hit = '0;
      for (int i = 0; i < 4; i++) begin
        if (orderLog[i] >= 40 && orderLog[i] < 44) hit[orderLog[i] - 40] = 1'b1;
      end
      check(hit == 4'hF, "R8", "first four grants cover all senders", hit, 15);
    end

    // R9 backpressure and R2 no loss across four full waves
    for (int w = 0; w < FIFO_DEPTH; w++) begin
      for (int s = 0; s < NUM_SENDERS; s++) begin
        stage(s, ROUTE_UNI, 3'd7, 4'(w), MY_CLUSTER, 4'(s % 16), 32'h9000_0000 | 32'(s * 8 + w));
        expectItem(s, 32'h9000_0000 | 32'(s * 8 + w), 3'd7, 4'(w), NUM_CORES'(1) << (s % 16));
      end
      tick();
    end
    check($countones(senderHold) >= 56, "R9", "hold raised on crowded senders", $countones(senderHold), 56);
    idle(150);
    check(senderHold == '0, "R9", "hold released after drain", $countones(senderHold), 0);
    checkQueuesEmpty("R2");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule